// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block steps through a ring of transmit descriptors kept in a small descriptor memory. Each descriptor takes two 32-bit words. The first is a status/control word and the second is a frame-buffer pointer. The walker polls the status word of the current descriptor. Once the ready flag is set, it loads the pointer and issues one read per cycle to the frame buffer, from the first byte to the last. A pointer does not have to be word aligned; the opening access masks off the byte lanes below the start byte.

After the last byte, the walker writes the status word back with ready cleared. If the descriptor asked for an interrupt, it raises a one-cycle pulse. It then moves to the next descriptor, or returns to descriptor 0 when the wrap flag is set. Frame data goes from the buffer memory straight to the downstream consumer. The walker only produces the read requests and their byte selects. A control-frame flag travels alongside each read.

The descriptor memory has a single synchronous port. Read data appears one cycle after the request.

Top module: `txd_ring_walker`

## Requirements
- R1: Descriptor k is addressed as follows: its status word is read at byte address k*8 and its buffer pointer at k*8+4.
- R2: Status word fields: byte count in bits 31:16, ready in bit 15, interrupt request in bit 14, wrap in bit 13, control-frame flag in bit 9. `frm_ctrl` carries bit 9 on every buffer read.
- R3: When the wrap bit is 1, the next status poll is at descriptor 0. Otherwise it is at the current index plus one, modulo the ring size 2^(DSC_AW-3).
- R4: The first buffer read goes to the pointer with bits 1:0 cleared. Its select depends on pointer bits 1:0: 0 gives 1111, 1 gives 0111, 2 gives 0011, 3 gives 0001 (bit 3 is the lowest byte lane).
- R5: The first read covers 4, 3, 2 or 1 bytes for offsets 0 to 3. Every later read has select 1111, covers 4 bytes and goes to the previous address plus 4. The walker issues exactly as many reads as it takes to cover the byte count.
- R6: Write-back writes, to the status address, the status word as it was read with bit 15 cleared and all other bits unchanged.
- R7: `irq` is high for exactly the write-back cycle, and only when bit 14 of the descriptor is 1.
- R8: While the current descriptor's ready bit is 0, the walker polls the same status address again and issues no buffer read.
- R9: A byte count of zero issues no buffer read and goes straight to write-back.
- R10: After reset the walker polls descriptor 0, with `buf_rd` and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsc_req | output | 1 | Descriptor memory access strobe |
| dsc_we | output | 1 | Write enable for the access |
| dsc_addr | output | DSC_AW | Descriptor byte address |
| dsc_wdata | output | 32 | Write data (status write-back) |
| dsc_rdata | input | 32 | Read data, valid one cycle after a read |
| buf_rd | output | 1 | Frame-buffer read request |
| buf_addr | output | 32 | Word-aligned buffer byte address |
| buf_sel | output | 4 | Byte-lane selects for the read |
| frm_ctrl | output | 1 | Control-frame flag of the current descriptor |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The in-RTL properties are checked on every cycle and cover local rules:
- reads after the first use full lanes and advance the address by one word;
- a write-back never carries a set ready bit;
- `irq` appears only together with a write-back;
- a not-ready status read returns to polling at the same index.

Some behaviour only shows up across the bench's sweep of every start offset against byte counts 0 to 9. That sweep, with varying flag combinations and a wrap in the ring, is what demonstrates:
- the exact number of reads per frame;
- the first-access mask for each offset;
- the preserved fields in the write-back;
- the index reached after a wrap.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
    typedef enum logic [2:0] {
        ST_POLL  = 3'd0,
        ST_STAT  = 3'd1,
        ST_PTR   = 3'd2,
        ST_XFER  = 3'd3,
        ST_WBACK = 3'd4
    } tdr_state_e;

    localparam int BIT_READY = 15;
    localparam int BIT_IRQ   = 14;
    localparam int BIT_WRAP  = 13;
    localparam int BIT_CTRL  = 9;
    localparam int LEN_LSB   = 16;
    localparam int LEN_W     = 16;
endpackage

// File: rtl/tdr_lane_sel.sv
module tdr_lane_sel (
    input  logic [1:0] off,
    input  logic       first,
    output logic [3:0] sel,
    output logic [2:0] adv
);
    always_comb begin
        if (first) begin
            sel = 4'hf >> off;
            adv = 3'd4 - {1'b0, off};
        end else begin
            sel = 4'hf;
            adv = 3'd4;
        end
    end
endmodule

// File: rtl/tdr_next_idx.sv
module tdr_next_idx #(
    parameter int IDX_W = 7
) (
    input  logic [IDX_W-1:0] cur,
    input  logic             wrap,
    output logic [IDX_W-1:0] nxt
);
    assign nxt = wrap ? '0 : cur + 1'b1;
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
    import tdr_pkg::*;
#(
    parameter int DSC_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              dsc_req,
    output logic              dsc_we,
    output logic [DSC_AW-1:0] dsc_addr,
    output logic [31:0]       dsc_wdata,
    input  logic [31:0]       dsc_rdata,
    output logic              buf_rd,
    output logic [31:0]       buf_addr,
    output logic [3:0]        buf_sel,
    output logic              frm_ctrl,
    output logic              irq
);
    localparam int IDX_W = DSC_AW - 3;

    typedef struct packed {
        tdr_state_e         st;
        logic [IDX_W-1:0]   idx;
        logic [31:0]        stat;
        logic [29:0]        word;
        logic [LEN_W-1:0]   remain;
        logic               first;
        logic [1:0]         off;
    } regs_t;

    regs_t r_q, r_d;

    logic [3:0]       lane_sel;
    logic [2:0]       lane_adv;
    logic [IDX_W-1:0] idx_nxt;

    tdr_lane_sel u_lane (
        .off   (r_q.off),
        .first (r_q.first),
        .sel   (lane_sel),
        .adv   (lane_adv)
    );

    tdr_next_idx #(.IDX_W(IDX_W)) u_step (
        .cur  (r_q.idx),
        .wrap (r_q.stat[BIT_WRAP]),
        .nxt  (idx_nxt)
    );

    always_comb begin
        r_d       = r_q;
        dsc_req   = 1'b0;
        dsc_we    = 1'b0;
        dsc_addr  = {r_q.idx, 3'b000};
        dsc_wdata = r_q.stat;
        buf_rd    = 1'b0;
        buf_addr  = {r_q.word, 2'b00};
        buf_sel   = lane_sel;
        frm_ctrl  = r_q.stat[BIT_CTRL];
        irq       = 1'b0;
        case (r_q.st)
            ST_POLL: begin
                dsc_req = 1'b1;
                r_d.st  = ST_STAT;
            end
            ST_STAT: begin
                r_d.stat = dsc_rdata;
                if (dsc_rdata[BIT_READY]) begin
                    dsc_req  = 1'b1;
                    dsc_addr = {r_q.idx, 3'b100};
                    r_d.st   = ST_PTR;
                end else begin
                    r_d.st   = ST_POLL;
                end
            end
            ST_PTR: begin
                r_d.word   = dsc_rdata[31:2];
                r_d.off    = dsc_rdata[1:0];
                r_d.first  = 1'b1;
                r_d.remain = r_q.stat[LEN_LSB +: LEN_W];
                r_d.st     = (r_q.stat[LEN_LSB +: LEN_W] == '0) ? ST_WBACK : ST_XFER;
            end
            ST_XFER: begin
                buf_rd    = 1'b1;
                r_d.first = 1'b0;
                r_d.word  = r_q.word + 30'd1;
                if (r_q.remain <= {{(LEN_W-3){1'b0}}, lane_adv}) begin
                    r_d.remain = '0;
                    r_d.st     = ST_WBACK;
                end else begin
                    r_d.remain = r_q.remain - {{(LEN_W-3){1'b0}}, lane_adv};
                end
            end
            ST_WBACK: begin
                dsc_req   = 1'b1;
                dsc_we    = 1'b1;
                dsc_wdata = r_q.stat & ~(32'd1 << BIT_READY);
                irq       = r_q.stat[BIT_IRQ];
                r_d.idx   = idx_nxt;
                r_d.st    = ST_POLL;
            end
            default: r_d.st = ST_POLL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R5: reads after the first are full-word and one word apart
    p_full_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd && $past(buf_rd) |-> buf_sel == 4'hf);
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd && $past(buf_rd) |-> buf_addr == $past(buf_addr) + 32'd4);
    // R6: a write-back never leaves ready set
    p_wb_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_req && dsc_we |-> !dsc_wdata[BIT_READY]);
    // R7: interrupt only alongside a write-back, and never two cycles running
    p_irq_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> dsc_req && dsc_we);
    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R8: not-ready status returns to polling the same index
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STAT && !dsc_rdata[BIT_READY]) |=> (r_q.st == ST_POLL && $stable(r_q.idx)));
    // R8: buffer reads never overlap descriptor traffic
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |-> !dsc_req);
endmodule

// File: tb/txd_ring_walker_bench.sv
module txd_ring_walker_bench;
    localparam int DSC_AW = 6;
    localparam int NDSC   = 1 << (DSC_AW - 3);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dsc_req, dsc_we;
    logic [DSC_AW-1:0] dsc_addr;
    logic [31:0]       dsc_wdata;
    logic [31:0]       dsc_rdata = '0;
    logic              buf_rd, frm_ctrl, irq;
    logic [31:0]       buf_addr;
    logic [3:0]        buf_sel;

    logic [31:0] mem [0:2*NDSC-1];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    txd_ring_walker #(.DSC_AW(DSC_AW)) u_txd_ring_walker (
        .clk(clk), .rst_n(rst_n),
        .dsc_req(dsc_req), .dsc_we(dsc_we), .dsc_addr(dsc_addr),
        .dsc_wdata(dsc_wdata), .dsc_rdata(dsc_rdata),
        .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_sel(buf_sel),
        .frm_ctrl(frm_ctrl), .irq(irq)
    );

    always @(posedge clk) begin
        if (dsc_req && dsc_we) mem[dsc_addr[DSC_AW-1:2]] <= dsc_wdata;
        else if (dsc_req)      dsc_rdata <= mem[dsc_addr[DSC_AW-1:2]];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int e_idx;
        int k;
        for (int i = 0; i < 2*NDSC; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk(dsc_req && !dsc_we && dsc_addr == 0, "R10", {26'd0, dsc_addr}, 32'd0);
        chk(!buf_rd && !irq, "R10", {30'd0, buf_rd, irq}, 32'd0);
        e_idx = 0;
        k = 0;
        for (int o = 0; o < 4; o++) begin
            for (int len = 0; len < 10; len++) begin
                logic [31:0] ptr, stat, exp_wb, a0;
                bit wrap, irqb, ctl, done, bad_stall;
                int nexp, n, first_adv, nxt_idx;
                wrap = (e_idx == 5);
                irqb = k[0];
                ctl  = k[1];
                ptr  = 32'h1000 + 32'h100 * k + o;
                stat = {len[15:0], 1'b1, irqb, wrap, 3'b000, ctl, 9'd0};
                exp_wb = stat & ~32'h8000;
                first_adv = 4 - o;
                if (len == 0) nexp = 0;
                else if (len <= first_adv) nexp = 1;
                else nexp = 1 + (len - first_adv + 3) / 4;
                a0 = ptr & ~32'h3;
                // R8: not-ready descriptor is re-polled at the same address
                bad_stall = 1'b0;
                for (int s = 0; s < 6; s++) begin
                    @(negedge clk);
                    if (buf_rd || irq || (dsc_req && (dsc_we || dsc_addr != e_idx*8))) bad_stall = 1'b1;
                end
                chk(!bad_stall, "R8", {26'd0, dsc_addr}, e_idx*8);
                mem[e_idx*2+1] = ptr;
                mem[e_idx*2]   = stat;
                n = 0;
                done = 1'b0;
                for (int t = 0; t < 100 && !done; t++) begin
                    @(negedge clk);
                    if (buf_rd) begin
                        // R4 / R5: address and lane selects per access
                        chk(buf_addr == a0 + 4*n, n == 0 ? "R4" : "R5", buf_addr, a0 + 4*n);
                        chk(buf_sel == (n == 0 ? (4'hf >> o) : 4'hf), n == 0 ? "R4" : "R5",
                            {28'd0, buf_sel}, {28'd0, (n == 0 ? (4'hf >> o) : 4'hf)});
                        chk(frm_ctrl == ctl, "R2", {31'd0, frm_ctrl}, {31'd0, ctl});
                        n++;
                    end
                    if (dsc_req && !dsc_we && dsc_addr[2])
                        chk(dsc_addr == e_idx*8 + 4, "R1", {26'd0, dsc_addr}, e_idx*8 + 4);
                    if (dsc_req && dsc_we) begin
                        chk(dsc_addr == e_idx*8, "R1", {26'd0, dsc_addr}, e_idx*8);
                        chk(dsc_wdata == exp_wb, "R6", dsc_wdata, exp_wb);
                        chk(irq == irqb, "R7", {31'd0, irq}, {31'd0, irqb});
                        done = 1'b1;
                    end else if (irq) begin
                        chk(1'b0, "R7", 32'd1, 32'd0);
                    end
                end
                chk(done, "R6", {31'd0, done}, 32'd1);
                chk(n == nexp, len == 0 ? "R9" : "R5", n, nexp);
                nxt_idx = wrap ? 0 : (e_idx + 1) % NDSC;
                @(negedge clk);
                // R3: next poll lands on the wrapped or incremented index
                chk(dsc_req && !dsc_we && dsc_addr == nxt_idx*8 && !irq, "R3", {26'd0, dsc_addr}, nxt_idx*8);
                e_idx = nxt_idx;
                k++;
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule